// File: doc/BRIEF.md
# Descriptor-Chained DMA Command Sequencer

This block is a single-channel engine that follows a chain of 16-byte command descriptors held in system memory. Software (through a separate register block) hands it a starting pointer. The engine reads the four 32-bit words of a descriptor, decodes the opcode and key, and executes the command. A command is one of these:
- a device data burst, in either direction, through a start/done handshake;
- a small load or store between memory and the descriptor's dependent word;
- a no-op;
- a stop.

When a command completes, the engine may park on a wait condition. Once it can proceed, it writes the dependent word and then the status/residual word back into the descriptor slot. It may then pulse its interrupt. Finally it either steps to the next slot or jumps to the address held in the dependent word. Condition matching against device status is done outside the block: the three `cond_match_i` bits report whether the selected device-status pattern currently matches.

Descriptor words in memory are little-endian:
- word 0 is {command[15:0], request count[15:0]};
- word 1 is the data address;
- word 2 is the dependent word (branch target or load/store data);
- word 3 is {transfer status[15:0], residual count[15:0]}.

Command bits:
- [15:12] are the opcode;
- [10:8] are the key;
- [5:4] are the interrupt select;
- [3:2] are the branch select;
- [1:0] are the wait select.

Each select field is coded as 0 never, 1 when the match bit is 1, 2 when it is 0, and 3 always. The status word has these fields:
- bit 15 active;
- bit 14 fault;
- bit 13 flush;
- bit 12 wake;
- bit 11 branched;
- bits 3:0 the device status input;
- all other bits zero.

Top module: `dsq_engine`

## Requirements
- R1: A fetch issues four word reads at pointer, pointer+4, pointer+8 and pointer+12, with the descriptor layout above; memory addresses are always word aligned.
- R2: Opcodes 0..7 mean output-more, output-last, input-more, input-last, store-word, load-word, no-op, stop; opcodes 8..15 fault the channel.
- R3: A fault sets status bit 14, clears bit 15 and pulses `irq_o` in the same cycle, with no write-back.
- R4: A data command with key above 3 or data address zero faults. Otherwise it pulses `dev_start_o` with the address, the request count as length, the direction (out for opcodes 0/1) and the last flag (opcodes 1/3). The residual written back is `dev_resid_i`.
- R5: Store-word and load-word use request bits 2:0. If bit 2 is set, 4 bytes are moved at the address aligned to 4. Otherwise, if bit 1 is set, 2 bytes are moved at the address aligned to 2. Otherwise 1 byte is moved. Load fills the low bytes of the dependent word and keeps the others. Store writes the low bytes of the dependent word to the lanes the address selects.
- R6: Store-word and load-word with key 4..7 fault; keys 0..3 act as the system key.
- R7: The wake bit (status bit 12) is cleared when a descriptor fetch completes; `wake_i` sets it and makes the channel active.
- R8: Stop clears active, fault and flush without moving the pointer, so a later `wake_i` refetches the same slot.
- R9: While the wait select is true the channel holds with no write-back, and it resumes when the condition drops.
- R10: Write-back stores the dependent word at pointer+8, then {status, residual} at pointer+12, with all byte enables set. No-op and load/store keep the fetched residual.
- R11: After write-back `irq_o` pulses when the interrupt select is true.
- R12: Advance adds 16 to the pointer and clears branched. Branch loads the dependent word (low 4 bits cleared) and sets branched. Load/store always advance.
- R13: Flush is cleared after an output-last or input-last command and after any load/store.
- R14: A memory request holds its address and direction until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, loads the pointer and activates (idle only) |
| start_ptr_i | input | 32 | First descriptor address |
| wake_i | input | 1 | Sets wake and active; restarts fetch when idle |
| flush_i | input | 1 | Sets the flush status bit |
| devstat_i | input | 4 | Device status bits reported in status |
| cond_match_i | input | 3 | Match results: [0] wait, [1] branch, [2] interrupt |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables |
| mem_ack_i | input | 1 | Request done; read data valid |
| mem_rdata_i | input | 32 | Read data |
| dev_start_o | output | 1 | Burst start pulse |
| dev_out_o | output | 1 | Burst direction, 1 = memory to device |
| dev_last_o | output | 1 | Last-buffer flag |
| dev_addr_o | output | 32 | Burst data address |
| dev_len_o | output | 16 | Burst length in bytes |
| dev_key_o | output | 3 | Burst key |
| dev_done_i | input | 1 | Burst done pulse |
| dev_resid_i | input | 16 | Bytes left at burst end |
| status_o | output | 16 | Channel status word |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bound checker watches several rules on every cycle:
- the memory handshake holds its request steady until the acknowledge;
- memory addresses stay word aligned;
- a rising fault comes with the interrupt and an inactive channel;
- the device start is a single-cycle pulse;
- an inactive channel issues no memory traffic.

Other behaviour can only be shown by the bench's descriptor chains, scored against an ordered list of expected events:
- the order and content of write-backs;
- the byte-lane arithmetic of load/store;
- branch versus advance;
- flush and wake clearing;
- parking on a wait;
- the pointer staying put after stop.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DSTAT_W    = 4;
    localparam int KEY_W      = 3;
    localparam int N_COND     = 3;
    localparam int DESC_BYTES = 16;
    localparam int DESC_WORDS = DESC_BYTES / (DATA_W / 8);
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int BE_W       = DATA_W / 8;

    localparam int ST_ACTIVE = 15;
    localparam int ST_FAULT  = 14;
    localparam int ST_FLUSH  = 13;
    localparam int ST_WAKE   = 12;
    localparam int ST_BRD    = 11;

    localparam int CI_WAIT = 0;
    localparam int CI_BR   = 1;
    localparam int CI_IRQ  = 2;

    typedef enum logic [3:0] {
        OP_OUT_MORE = 4'd0,
        OP_OUT_LAST = 4'd1,
        OP_IN_MORE  = 4'd2,
        OP_IN_LAST  = 4'd3,
        OP_ST_WORD  = 4'd4,
        OP_LD_WORD  = 4'd5,
        OP_NOP      = 4'd6,
        OP_STOP     = 4'd7
    } op_e;

    typedef enum logic [1:0] {
        CND_NEVER   = 2'd0,
        CND_IFMATCH = 2'd1,
        CND_IFMISS  = 2'd2,
        CND_ALWAYS  = 2'd3
    } cond_e;

    typedef struct packed {
        logic             valid;
        logic             is_data;
        logic             is_ls;
        logic             is_load;
        logic             is_nop;
        logic             is_stop;
        logic             dir_out;
        logic             last;
        logic [KEY_W-1:0] key;
        cond_e            intr;
        cond_e            br;
        cond_e            wt;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_EXEC, S_DEV, S_LDRD, S_STWR, S_WAIT, S_WB, S_FIN
    } state_e;

    function automatic logic cond_fire(cond_e sel, logic match);
        case (sel)
            CND_NEVER:   return 1'b0;
            CND_IFMATCH: return match;
            CND_IFMISS:  return !match;
            default:     return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/dsq_cmd_decode.sv
module dsq_cmd_decode
    import dsq_pkg::*;
(
    input  logic [CNT_W-1:0] cmd_word,
    output cmd_t             dec
);
    op_e  op;
    logic unused_cmd_bits;

    assign op              = op_e'(cmd_word[15:12]);
    assign unused_cmd_bits = ^{cmd_word[11], cmd_word[7:6]};

    always_comb begin
        dec         = '0;
        dec.key     = cmd_word[10:8];
        dec.intr    = cond_e'(cmd_word[5:4]);
        dec.br      = cond_e'(cmd_word[3:2]);
        dec.wt      = cond_e'(cmd_word[1:0]);
        dec.valid   = !cmd_word[15];
        case (op)
            OP_OUT_MORE: begin dec.is_data = 1'b1; dec.dir_out = 1'b1; end
            OP_OUT_LAST: begin dec.is_data = 1'b1; dec.dir_out = 1'b1; dec.last = 1'b1; end
            OP_IN_MORE:  dec.is_data = 1'b1;
            OP_IN_LAST:  begin dec.is_data = 1'b1; dec.last = 1'b1; end
            OP_ST_WORD:  dec.is_ls = 1'b1;
            OP_LD_WORD:  begin dec.is_ls = 1'b1; dec.is_load = 1'b1; end
            OP_NOP:      dec.is_nop = 1'b1;
            OP_STOP:     dec.is_stop = 1'b1;
            default:     dec.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsq_cond_sel.sv
module dsq_cond_sel
    import dsq_pkg::*;
(
    input  cond_e sel,
    input  logic  match,
    output logic  fire
);
    assign fire = cond_fire(sel, match);
endmodule

// File: rtl/dsq_ls_lane.sv
module dsq_ls_lane
    import dsq_pkg::*;
(
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [2:0]        req_lo,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] dep_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dep_merged
);
    logic [1:0]        off;
    logic [BE_W-1:0]   mask;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        if (req_lo[2]) begin
            off  = 2'd0;
            mask = 4'hF;
        end else if (req_lo[1]) begin
            off  = {byte_addr[1], 1'b0};
            mask = 4'h3;
        end else begin
            off  = byte_addr[1:0];
            mask = 4'h1;
        end
    end

    assign word_addr = {byte_addr[ADDR_W-1:2], 2'b00};
    assign be        = mask << off;
    assign wdata     = dep_in << {off, 3'b000};
    assign shifted   = rdata >> {off, 3'b000};

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign dep_merged[8*b +: 8] = mask[b] ? shifted[8*b +: 8] : dep_in[8*b +: 8];
    end
endmodule

// File: rtl/dsq_engine.sv
module dsq_engine
    import dsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   start_ptr_i,
    input  logic                wake_i,
    input  logic                flush_i,
    input  logic [DSTAT_W-1:0]  devstat_i,
    input  logic [N_COND-1:0]   cond_match_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic [BE_W-1:0]     mem_be_o,
    input  logic                mem_ack_i,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                dev_start_o,
    output logic                dev_out_o,
    output logic                dev_last_o,
    output logic [ADDR_W-1:0]   dev_addr_o,
    output logic [CNT_W-1:0]    dev_len_o,
    output logic [KEY_W-1:0]    dev_key_o,
    input  logic                dev_done_i,
    input  logic [CNT_W-1:0]    dev_resid_i,
    output logic [CNT_W-1:0]    status_o,
    output logic                irq_o
);
    localparam logic [ADDR_W-1:0] SLOT_MASK = ~ADDR_W'(DESC_BYTES - 1);
    localparam logic [ADDR_W-1:0] WB_OFS    = ADDR_W'(8);

    state_e             st_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ADDR_W-1:0]  ptr_q, daddr_q;
    logic [DATA_W-1:0]  dep_q;
    logic [CNT_W-1:0]   req_q, cmdw_q, resid_q;
    logic               act_q, fault_q, flush_q, wake_q, brd_q;
    logic               irq_q, dstart_q;

    cmd_t               dec;
    cond_e              sel_v [N_COND];
    logic [N_COND-1:0]  fire;
    logic [ADDR_W-1:0]  ls_addr;
    logic [BE_W-1:0]    ls_be;
    logic [DATA_W-1:0]  ls_wdata, ls_dep;
    logic [ADDR_W-1:0]  idx_ofs;

    dsq_cmd_decode u_dec (.cmd_word(cmdw_q), .dec(dec));

    assign sel_v[CI_WAIT] = dec.wt;
    assign sel_v[CI_BR]   = dec.br;
    assign sel_v[CI_IRQ]  = dec.intr;

    for (genvar g = 0; g < N_COND; g++) begin : g_cond
        dsq_cond_sel u_cs (.sel(sel_v[g]), .match(cond_match_i[g]), .fire(fire[g]));
    end

    dsq_ls_lane u_lane (
        .byte_addr (daddr_q),
        .req_lo    (req_q[2:0]),
        .rdata     (mem_rdata_i),
        .dep_in    (dep_q),
        .word_addr (ls_addr),
        .be        (ls_be),
        .wdata     (ls_wdata),
        .dep_merged(ls_dep)
    );

    assign status_o = {act_q, fault_q, flush_q, wake_q, brd_q,
                       {(CNT_W-DSTAT_W-5){1'b0}}, devstat_i};
    assign irq_o       = irq_q;
    assign dev_start_o = dstart_q;
    assign dev_out_o   = dec.dir_out;
    assign dev_last_o  = dec.last;
    assign dev_addr_o  = daddr_q;
    assign dev_len_o   = req_q;
    assign dev_key_o   = dec.key;
    assign idx_ofs     = {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ptr_q + idx_ofs;
        mem_wdata_o = '0;
        mem_be_o    = '1;
        case (st_q)
            S_FETCH: mem_req_o = 1'b1;
            S_LDRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ls_addr;
            end
            S_STWR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ls_addr;
                mem_wdata_o = ls_wdata;
                mem_be_o    = ls_be;
            end
            S_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_q + WB_OFS + idx_ofs;
                mem_wdata_o = (idx_q == '0) ? dep_q : {status_o, resid_q};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            idx_q    <= '0;
            ptr_q    <= '0;
            daddr_q  <= '0;
            dep_q    <= '0;
            req_q    <= '0;
            cmdw_q   <= '0;
            resid_q  <= '0;
            act_q    <= 1'b0;
            fault_q  <= 1'b0;
            flush_q  <= 1'b0;
            wake_q   <= 1'b0;
            brd_q    <= 1'b0;
            irq_q    <= 1'b0;
            dstart_q <= 1'b0;
        end else begin
            irq_q    <= 1'b0;
            dstart_q <= 1'b0;
            if (flush_i) flush_q <= 1'b1;
            if (wake_i) begin
                wake_q <= 1'b1;
                act_q  <= 1'b1;
            end
            case (st_q)
                S_IDLE: begin
                    idx_q <= '0;
                    if (start_i) begin
                        ptr_q   <= start_ptr_i & SLOT_MASK;
                        act_q   <= 1'b1;
                        fault_q <= 1'b0;
                        st_q    <= S_FETCH;
                    end else if (wake_i) begin
                        st_q <= S_FETCH;
                    end
                end
                S_FETCH: if (mem_ack_i) begin
                    case (idx_q)
                        2'd0:    {cmdw_q, req_q} <= mem_rdata_i;
                        2'd1:    daddr_q <= mem_rdata_i;
                        2'd2:    dep_q <= mem_rdata_i;
                        default: resid_q <= mem_rdata_i[CNT_W-1:0];
                    endcase
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
                        wake_q <= 1'b0;
                        st_q   <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    idx_q <= '0;
                    if (!dec.valid ||
                        (dec.is_data && (dec.key[2] || daddr_q == '0)) ||
                        (dec.is_ls && dec.key[2])) begin
                        fault_q <= 1'b1;
                        act_q   <= 1'b0;
                        irq_q   <= 1'b1;
                        st_q    <= S_IDLE;
                    end else if (dec.is_stop) begin
                        act_q   <= 1'b0;
                        fault_q <= 1'b0;
                        flush_q <= 1'b0;
                        st_q    <= S_IDLE;
                    end else if (dec.is_data) begin
                        dstart_q <= 1'b1;
                        st_q     <= S_DEV;
                    end else if (dec.is_ls) begin
                        st_q <= dec.is_load ? S_LDRD : S_STWR;
                    end else begin
                        st_q <= S_WAIT;
                    end
                end
                S_DEV: if (dev_done_i) begin
                    resid_q <= dev_resid_i;
                    st_q    <= S_WAIT;
                end
                S_LDRD: if (mem_ack_i) begin
                    dep_q <= ls_dep;
                    st_q  <= S_WAIT;
                end
                S_STWR: if (mem_ack_i) st_q <= S_WAIT;
                S_WAIT: if (!fire[CI_WAIT]) begin
                    idx_q <= '0;
                    st_q  <= S_WB;
                end
                S_WB: if (mem_ack_i) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q != '0) st_q <= S_FIN;
                end
                S_FIN: begin
                    idx_q <= '0;
                    irq_q <= fire[CI_IRQ];
                    if (dec.is_ls || (dec.is_data && dec.last)) flush_q <= 1'b0;
                    if (!dec.is_ls && fire[CI_BR]) begin
                        ptr_q <= dep_q & SLOT_MASK;
                        brd_q <= 1'b1;
                    end else begin
                        ptr_q <= ptr_q + ADDR_W'(DESC_BYTES);
                        brd_q <= 1'b0;
                    end
                    st_q <= S_FETCH;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsq_engine_chk.sv
module dsq_engine_chk
    import dsq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mem_req_o,
    input logic               mem_we_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               mem_ack_i,
    input logic               dev_start_o,
    input logic [CNT_W-1:0]   status_o,
    input logic               irq_o
);
    assert_req_hold_R14: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    assert_fault_irq_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[ST_FAULT]) |-> irq_o);

    assert_fault_inactive_R3: assert property (@(posedge clk) disable iff (rst)
        status_o[ST_FAULT] |-> !status_o[ST_ACTIVE]);

    assert_dev_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        dev_start_o |=> !dev_start_o);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !status_o[ST_ACTIVE] |-> (!mem_req_o && !dev_start_o));
endmodule

bind dsq_engine dsq_engine_chk u_dsq_engine_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .dev_start_o(dev_start_o),
    .status_o   (status_o),
    .irq_o      (irq_o)
);

// File: tb/test_dsq_engine.sv
`timescale 1ns/1ps
module test_dsq_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_ptr_i = '0;
    logic        wake_i = 1'b0;
    logic        flush_i = 1'b0;
    logic [3:0]  devstat_i = 4'h5;
    logic [2:0]  cond_match_i = 3'b000;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o;
    logic        dev_start_o, dev_out_o, dev_last_o, dev_done_i;
    logic [31:0] dev_addr_o;
    logic [15:0] dev_len_o, dev_resid_i;
    logic [2:0]  dev_key_o;
    logic [15:0] status_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    dsq_engine i_dsq_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .start_ptr_i(start_ptr_i),
        .wake_i(wake_i), .flush_i(flush_i), .devstat_i(devstat_i),
        .cond_match_i(cond_match_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .dev_start_o(dev_start_o),
        .dev_out_o(dev_out_o), .dev_last_o(dev_last_o), .dev_addr_o(dev_addr_o),
        .dev_len_o(dev_len_o), .dev_key_o(dev_key_o), .dev_done_i(dev_done_i),
        .dev_resid_i(dev_resid_i), .status_o(status_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } ev_t;
    localparam logic [1:0] K_WR = 2'd0, K_DEV = 2'd1, K_IRQ = 2'd2;
    ev_t   exp_q[$];
    string tag_q[$];

    // memory model, one-cycle acknowledge
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (rst) mem_ack_i <= 1'b0;
        else if (mem_req_o && !mem_ack_i) begin
            mem_ack_i   <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[9:2]];
            if (mem_we_o)
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
        end else mem_ack_i <= 1'b0;
    end

    // device model
    int dcnt;
    assign dev_resid_i = 16'd5;
    always @(posedge clk) begin
        if (rst) begin dcnt <= 0; dev_done_i <= 1'b0; end
        else begin
            dev_done_i <= 1'b0;
            if (dev_start_o) dcnt <= 3;
            else if (dcnt != 0) begin
                dcnt <= dcnt - 1;
                if (dcnt == 1) dev_done_i <= 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] be, input string tag);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.be = be;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic observe(input ev_t got);
        ev_t   e;
        string t;
        if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected event", {got.kind, got.addr, got.data[29:0]}, 64'd0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got == e, t, {got.kind, got.addr, got.data[29:0]}, {e.kind, e.addr, e.data[29:0]});
            if (got.data != e.data || got.be != e.be)
                $display("  detail %s data %h/%h be %h/%h", t, got.data, e.data, got.be, e.be);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req_o && mem_we_o && mem_ack_i)
                observe({K_WR, mem_addr_o, mem_wdata_o, mem_be_o});
            if (dev_start_o)
                observe({K_DEV, dev_addr_o, {14'd0, dev_out_o, dev_last_o, dev_len_o}, 4'hF});
            if (irq_o)
                observe({K_IRQ, 32'd0, 32'd0, 4'hF});
        end
    end

    task automatic put_desc(input int base, input logic [15:0] req, input logic [15:0] cmd,
                            input logic [31:0] addr, input logic [31:0] dep);
        mem[base/4]     = {cmd, req};
        mem[base/4 + 1] = addr;
        mem[base/4 + 2] = dep;
        mem[base/4 + 3] = 32'd0;
    endtask

    task automatic pulse_start(input logic [31:0] p);
        @(negedge clk); start_ptr_i = p; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        @(negedge clk);
        while (status_o[15] && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        check(!status_o[15], {tag, " channel idle"}, 64'(status_o), 64'd0);
        check(exp_q.size() == 0, {tag, " all expected events seen"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        mem[32'h204/4] = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status_o == 16'h0005, "R3 reset status", 64'(status_o), 64'h0005);
        check(!irq_o && !mem_req_o && !dev_start_o, "R1 reset quiet outputs",
              64'({irq_o, mem_req_o, dev_start_o}), 64'd0);

        // chain: output-last, no-op branch, store, load x2, stop
        put_desc(32'h40, 16'd32, 16'h1030, 32'h200, 32'hAAAA0001);
        put_desc(32'h50, 16'd0,  16'h600C, 32'h0,   32'h100);
        put_desc(32'h100, 16'd2, 16'h400C, 32'h303, 32'h1234ABCD);
        put_desc(32'h110, 16'd4, 16'h5000, 32'h206, 32'h0);
        put_desc(32'h120, 16'd1, 16'h5200, 32'h207, 32'h11223344);
        put_desc(32'h130, 16'd0, 16'h7000, 32'h0,   32'h0);
        expect_ev(K_DEV, 32'h200, 32'h30020, 4'hF, "R4 output-last burst");
        expect_ev(K_WR, 32'h48, 32'hAAAA0001, 4'hF, "R10 dep word write-back");
        expect_ev(K_WR, 32'h4C, 32'hA0050005, 4'hF, "R13 status with flush and residual");
        expect_ev(K_IRQ, 0, 0, 4'hF, "R11 interrupt always");
        expect_ev(K_WR, 32'h58, 32'h100, 4'hF, "R10 no-op write-back");
        expect_ev(K_WR, 32'h5C, 32'h80050000, 4'hF, "R13 flush cleared after last");
        expect_ev(K_WR, 32'h300, 32'hABCD0000, 4'hC, "R5 store two bytes aligned");
        expect_ev(K_WR, 32'h108, 32'h1234ABCD, 4'hF, "R12 branch taken to 0x100");
        expect_ev(K_WR, 32'h10C, 32'h88050000, 4'hF, "R12 branched status bit");
        expect_ev(K_WR, 32'h118, 32'hDEADBEEF, 4'hF, "R12 store advanced despite branch select");
        expect_ev(K_WR, 32'h11C, 32'h80050000, 4'hF, "R12 advance clears branched");
        expect_ev(K_WR, 32'h128, 32'h112233DE, 4'hF, "R6 load one byte with key 2");
        expect_ev(K_WR, 32'h12C, 32'h80050000, 4'hF, "R10 load status word");
        @(negedge clk); flush_i = 1'b1; @(negedge clk); flush_i = 1'b0;
        pulse_start(32'h40);
        wait_idle("R2 chain");
        check(status_o == 16'h0005, "R8 status after stop", 64'(status_o), 64'h0005);
        check(mem[32'h300/4] == 32'hABCD0000, "R5 memory after store", 64'(mem[32'h300/4]), 64'hABCD0000);

        // fault cases
        put_desc(32'h140, 16'd8, 16'h0000, 32'h0,   32'h0);
        put_desc(32'h150, 16'd8, 16'h2400, 32'h200, 32'h0);
        put_desc(32'h160, 16'd8, 16'h9000, 32'h200, 32'h0);
        put_desc(32'h170, 16'd4, 16'h4500, 32'h200, 32'h0);
        expect_ev(K_IRQ, 0, 0, 4'hF, "R4 zero address faults");
        pulse_start(32'h140); wait_idle("R4 zero address");
        check(status_o == 16'h4005, "R3 fault status", 64'(status_o), 64'h4005);
        expect_ev(K_IRQ, 0, 0, 4'hF, "R4 key 4 faults");
        pulse_start(32'h150); wait_idle("R4 key 4");
        check(status_o == 16'h4005, "R3 fault status key", 64'(status_o), 64'h4005);
        expect_ev(K_IRQ, 0, 0, 4'hF, "R2 undefined opcode faults");
        pulse_start(32'h160); wait_idle("R2 opcode 9");
        check(status_o == 16'h4005, "R2 fault status opcode", 64'(status_o), 64'h4005);
        expect_ev(K_IRQ, 0, 0, 4'hF, "R6 store key 5 faults");
        pulse_start(32'h170); wait_idle("R6 key 5");
        check(mem[32'h200/4] == 32'h0, "R6 no store after fault", 64'(mem[32'h200/4]), 64'd0);

        // wait park, wake bit, conditional branch and interrupt
        put_desc(32'h180, 16'd0, 16'h6019, 32'h0,   32'h1A0);
        put_desc(32'h1A0, 16'd8, 16'h2300, 32'h240, 32'h0);
        put_desc(32'h1B0, 16'd0, 16'h7000, 32'h0,   32'h0);
        cond_match_i = 3'b101;
        pulse_start(32'h180);
        repeat (40) @(negedge clk);
        check(status_o == 16'h8005, "R9 parked and active", 64'(status_o), 64'h8005);
        check(mem[32'h18C/4] == 32'h0, "R9 no write-back while parked", 64'(mem[32'h18C/4]), 64'd0);
        pulse_wake();
        check(status_o[12], "R7 wake sets bit", 64'(status_o), 64'h9005);
        expect_ev(K_WR, 32'h188, 32'h1A0, 4'hF, "R9 write-back after release");
        expect_ev(K_WR, 32'h18C, 32'h90050000, 4'hF, "R7 wake visible before fetch");
        expect_ev(K_IRQ, 0, 0, 4'hF, "R11 interrupt if match");
        expect_ev(K_DEV, 32'h240, 32'h8, 4'hF, "R12 branch on miss reached input burst");
        expect_ev(K_WR, 32'h1A8, 32'h0, 4'hF, "R10 input dep write-back");
        expect_ev(K_WR, 32'h1AC, 32'h88050005, 4'hF, "R7 wake cleared by fetch");
        @(negedge clk); cond_match_i = 3'b100;
        wait_idle("R9 park chain");

        // stop keeps pointer
        put_desc(32'h1B0, 16'd0, 16'h6030, 32'h0, 32'h77);
        put_desc(32'h1C0, 16'd0, 16'h7000, 32'h0, 32'h0);
        expect_ev(K_WR, 32'h1B8, 32'h77, 4'hF, "R8 refetch at stop slot");
        expect_ev(K_WR, 32'h1BC, 32'h80050000, 4'hF, "R8 resumed status");
        expect_ev(K_IRQ, 0, 0, 4'hF, "R11 resumed interrupt");
        pulse_wake();
        wait_idle("R8 resume");
        check(status_o == 16'h0005, "R8 final status", 64'(status_o), 64'h0005);
        summary();
    end
endmodule